// File: doc/BRIEF.md
# Shared Register Port Arbiter

This block lets two masters share one transceiver register port. The first master is the internal phase-control loop, which writes to the port continuously while the block runs. The second is an outside user port. By default the internal loop owns the port. A user who wants the port raises a request. Busy falls when the user has the port, and the user then drives enable, write-enable, an 8-bit address and 16-bit data. The port's ready strobe is returned to whichever side owns the port.

Taking the port is a one-way event. When the request is first seen, the internal loop is halted. If a loop write is still waiting for its ready, busy stays high until that ready arrives. When the user drops the request, the port locks: busy rises and neither side reaches the port. A restart flag stays raised until a one-cycle synchronous reset returns ownership to the loop. Everything runs on one clock.

Top module: `regport_arbiter`

## Requirements
- R1: During and just after reset: busy is 1, the restart flag is 0, halt is 0, and the port carries the internal loop's enable, write-enable, address and data.
- R2: While the loop owns the port and no request is high, loop strobes, address and data reach the port in the same cycle. User strobes, address and data have no effect on the port.
- R3: If a request is sampled high while the loop owns the port and no loop write is outstanding, busy is 0 from the next cycle.
- R4: If a loop write has been issued and its ready has not yet come back when the request is sampled, busy stays 1. Busy falls in the cycle after the edge at which the port ready is sampled high.
- R5: In any cycle with the request high, no loop strobe reaches the port, and the halt output to the loop is 1.
- R6: While busy is 0, the port carries the user enable, write-enable, address and data in the same cycle, and loop strobes are ignored.
- R7: Port ready is passed in the same cycle to the user ready output while busy is 0. While the loop owns the port, or while it drains its last write, port ready goes to the loop ready output. The two ready outputs are never high together.
- R8: A request that falls while busy is 0 makes busy 1 from the next edge. It then stays 1, and port enable and write-enable stay 0 whatever either side drives, until reset.
- R9: The restart flag is 1 from the edge at which a request is first taken until a one-cycle reset. After that reset, loop strobes reach the port again.
- R10: User strobes presented while busy is 1 (while draining or locked) leave port enable at 0 and the address and data at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| loop_en_i | input | 1 | Internal loop access strobe |
| loop_we_i | input | 1 | Internal loop write-enable |
| loop_addr_i | input | ADDR_W | Internal loop register address |
| loop_data_i | input | DATA_W | Internal loop write data |
| loop_rdy_o | output | 1 | Port ready returned to the loop |
| loop_halt_o | output | 1 | Tells the loop to stop issuing writes |
| usr_req_i | input | 1 | User request for the port |
| usr_en_i | input | 1 | User access strobe |
| usr_we_i | input | 1 | User write-enable |
| usr_addr_i | input | ADDR_W | User register address |
| usr_data_i | input | DATA_W | User write data |
| usr_rdy_o | output | 1 | Port ready returned to the user |
| usr_busy_o | output | 1 | Port not available to the user while high |
| port_en_o | output | 1 | Access strobe to the transceiver port |
| port_we_o | output | 1 | Write-enable to the transceiver port |
| port_addr_o | output | ADDR_W | Address to the transceiver port |
| port_data_o | output | DATA_W | Write data to the transceiver port |
| port_rdy_i | input | 1 | Ready from the transceiver port |
| restart_o | output | 1 | Loop is stopped and needs a reset to resume |

## Verification
The port strobes, address, data and both ready outputs are combinational. They are due in the same cycle as the input that causes them. Busy, the restart flag and the lock respond at the first clock edge that samples the request or the port ready. The bench drives inputs on the falling edge and compares every output a short delay later. It checks against a behavioural owner model that advances only on the rising edge, so each check sees the settled result of the current inputs on top of the state from the last edge. The drain case holds ready back for several cycles to show that busy waits exactly until the edge after ready is sampled.

// File: rtl/regarb_pkg.sv
package regarb_pkg;

    typedef enum logic [1:0] {
        OWN_LOOP  = 2'd0,
        OWN_DRAIN = 2'd1,
        OWN_USER  = 2'd2,
        OWN_LOCK  = 2'd3
    } owner_e;

    typedef struct packed {
        logic en;
        logic we;
    } strobe_t;

    localparam strobe_t STROBE_IDLE = '{en: 1'b0, we: 1'b0};

    function automatic logic loop_path_open(owner_e own, logic req);
        return (own == OWN_LOOP) && !req;
    endfunction

    function automatic logic loop_hears_ready(owner_e own);
        return (own == OWN_LOOP) || (own == OWN_DRAIN);
    endfunction

endpackage

// File: rtl/regarb_owner_fsm.sv
module regarb_owner_fsm
    import regarb_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   usr_req_i,
    input  logic   loop_en_i,
    input  logic   port_rdy_i,
    output owner_e owner_o,
    output logic   busy_o,
    output logic   restart_o,
    output logic   halt_o
);

    owner_e own_q, own_d;
    logic   pend_q, pend_d;
    logic   loop_issue;

    assign loop_issue = loop_en_i && loop_path_open(own_q, usr_req_i);

    always_comb begin
        own_d  = own_q;
        pend_d = pend_q;
        if (loop_issue) begin
            pend_d = 1'b1;
        end else if (port_rdy_i) begin
            pend_d = 1'b0;
        end
        case (own_q)
            OWN_LOOP: begin
                if (usr_req_i) begin
                    own_d = (pend_q && !port_rdy_i) ? OWN_DRAIN : OWN_USER;
                end
            end
            OWN_DRAIN: begin
                if (port_rdy_i) begin
                    own_d = OWN_USER;
                end
            end
            OWN_USER: begin
                if (!usr_req_i) begin
                    own_d = OWN_LOCK;
                end
            end
            default: own_d = OWN_LOCK;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            own_q  <= OWN_LOOP;
            pend_q <= 1'b0;
        end else begin
            own_q  <= own_d;
            pend_q <= pend_d;
        end
    end

    assign owner_o   = own_q;
    assign busy_o    = (own_q != OWN_USER);
    assign restart_o = (own_q != OWN_LOOP);
    assign halt_o    = (own_q != OWN_LOOP) || usr_req_i;

    // R3: the grant only follows a sampled request
    assert_grant_needs_req_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_o) |-> $past(usr_req_i));

    // R4: no grant while a loop write awaits its ready
    assert_no_grant_pending_R4: assert property (@(posedge clk) disable iff (rst)
        (own_q == OWN_USER) |-> !pend_q);

    // R8: the lock holds until reset
    assert_lock_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        (own_q == OWN_LOCK) |=> (own_q == OWN_LOCK) && busy_o);

    // R9: once raised, the restart flag stays up until reset
    assert_restart_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        restart_o |=> restart_o);

endmodule

// File: rtl/regarb_port_mux.sv
module regarb_port_mux
    import regarb_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  owner_e            owner_i,
    input  logic              usr_req_i,
    input  strobe_t           loop_stb_i,
    input  logic [ADDR_W-1:0] loop_addr_i,
    input  logic [DATA_W-1:0] loop_data_i,
    input  strobe_t           usr_stb_i,
    input  logic [ADDR_W-1:0] usr_addr_i,
    input  logic [DATA_W-1:0] usr_data_i,
    output strobe_t           port_stb_o,
    output logic [ADDR_W-1:0] port_addr_o,
    output logic [DATA_W-1:0] port_data_o
);

    always_comb begin
        port_stb_o  = STROBE_IDLE;
        port_addr_o = '0;
        port_data_o = '0;
        case (owner_i)
            OWN_LOOP: begin
                if (loop_path_open(owner_i, usr_req_i)) begin
                    port_stb_o = loop_stb_i;
                end
                port_addr_o = loop_addr_i;
                port_data_o = loop_data_i;
            end
            OWN_USER: begin
                port_stb_o  = usr_stb_i;
                port_addr_o = usr_addr_i;
                port_data_o = usr_data_i;
            end
            default: begin
                port_stb_o  = STROBE_IDLE;
            end
        endcase
    end

    // R5: a raised request blocks loop strobes at once
    assert_req_blocks_loop_R5: assert property (@(posedge clk) disable iff (rst)
        (usr_req_i && owner_i == OWN_LOOP) |-> !port_stb_o.en && !port_stb_o.we);

    // R10: nothing reaches the port while draining or locked
    assert_quiet_when_busy_R10: assert property (@(posedge clk) disable iff (rst)
        (owner_i == OWN_DRAIN || owner_i == OWN_LOCK) |-> (port_stb_o == STROBE_IDLE));

endmodule

// File: rtl/regarb_rdy_route.sv
module regarb_rdy_route
    import regarb_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  owner_e owner_i,
    input  logic   port_rdy_i,
    output logic   loop_rdy_o,
    output logic   usr_rdy_o
);

    assign loop_rdy_o = port_rdy_i && loop_hears_ready(owner_i);
    assign usr_rdy_o  = port_rdy_i && (owner_i == OWN_USER);

    // R7: ready reaches at most one side
    assert_rdy_one_side_R7: assert property (@(posedge clk) disable iff (rst)
        $onehot0({loop_rdy_o, usr_rdy_o}));

endmodule

// File: rtl/regport_arbiter.sv
module regport_arbiter
    import regarb_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              loop_en_i,
    input  logic              loop_we_i,
    input  logic [ADDR_W-1:0] loop_addr_i,
    input  logic [DATA_W-1:0] loop_data_i,
    output logic              loop_rdy_o,
    output logic              loop_halt_o,
    input  logic              usr_req_i,
    input  logic              usr_en_i,
    input  logic              usr_we_i,
    input  logic [ADDR_W-1:0] usr_addr_i,
    input  logic [DATA_W-1:0] usr_data_i,
    output logic              usr_rdy_o,
    output logic              usr_busy_o,
    output logic              port_en_o,
    output logic              port_we_o,
    output logic [ADDR_W-1:0] port_addr_o,
    output logic [DATA_W-1:0] port_data_o,
    input  logic              port_rdy_i,
    output logic              restart_o
);

    owner_e  owner;
    strobe_t loop_stb, usr_stb, port_stb;

    assign loop_stb = '{en: loop_en_i, we: loop_we_i};
    assign usr_stb  = '{en: usr_en_i,  we: usr_we_i};

    regarb_owner_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .usr_req_i  (usr_req_i),
        .loop_en_i  (loop_en_i),
        .port_rdy_i (port_rdy_i),
        .owner_o    (owner),
        .busy_o     (usr_busy_o),
        .restart_o  (restart_o),
        .halt_o     (loop_halt_o)
    );

    regarb_port_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mux (
        .clk         (clk),
        .rst         (rst),
        .owner_i     (owner),
        .usr_req_i   (usr_req_i),
        .loop_stb_i  (loop_stb),
        .loop_addr_i (loop_addr_i),
        .loop_data_i (loop_data_i),
        .usr_stb_i   (usr_stb),
        .usr_addr_i  (usr_addr_i),
        .usr_data_i  (usr_data_i),
        .port_stb_o  (port_stb),
        .port_addr_o (port_addr_o),
        .port_data_o (port_data_o)
    );

    regarb_rdy_route u_rdy (
        .clk        (clk),
        .rst        (rst),
        .owner_i    (owner),
        .port_rdy_i (port_rdy_i),
        .loop_rdy_o (loop_rdy_o),
        .usr_rdy_o  (usr_rdy_o)
    );

    assign port_en_o = port_stb.en;
    assign port_we_o = port_stb.we;

    // R6: a granted user strobe reaches the port in the same cycle
    assert_user_passes_R6: assert property (@(posedge clk) disable iff (rst)
        (!usr_busy_o && usr_en_i) |-> port_en_o && (port_addr_o == usr_addr_i));

endmodule

// File: tb/regport_arbiter_bench.sv
module regport_arbiter_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        loop_en = 0, loop_we = 0, usr_req = 0, usr_en = 0, usr_we = 0, port_rdy = 0;
    logic [7:0]  loop_addr = 0, usr_addr = 0, port_addr;
    logic [15:0] loop_data = 0, usr_data = 0, port_data;
    logic        loop_rdy, loop_halt, usr_rdy, usr_busy, port_en, port_we, restart;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference owner model: 0 loop, 1 drain, 2 user, 3 locked
    int m_own = 0;
    bit m_pend = 0;

    always #4 clk = ~clk;

    regport_arbiter u_regport_arbiter (
        .clk(clk), .rst(rst),
        .loop_en_i(loop_en), .loop_we_i(loop_we), .loop_addr_i(loop_addr), .loop_data_i(loop_data),
        .loop_rdy_o(loop_rdy), .loop_halt_o(loop_halt),
        .usr_req_i(usr_req), .usr_en_i(usr_en), .usr_we_i(usr_we), .usr_addr_i(usr_addr),
        .usr_data_i(usr_data), .usr_rdy_o(usr_rdy), .usr_busy_o(usr_busy),
        .port_en_o(port_en), .port_we_o(port_we), .port_addr_o(port_addr), .port_data_o(port_data),
        .port_rdy_i(port_rdy), .restart_o(restart)
    );

    always @(posedge clk) begin
        if (rst) begin
            m_own  = 0;
            m_pend = 0;
        end else begin
            bit issued;
            int nxt;
            issued = (m_own == 0) && loop_en && !usr_req;
            nxt = m_own;
            if (m_own == 0 && usr_req) nxt = (m_pend && !port_rdy) ? 1 : 2;
            else if (m_own == 1 && port_rdy) nxt = 2;
            else if (m_own == 2 && !usr_req) nxt = 3;
            if (issued) m_pend = 1;
            else if (port_rdy) m_pend = 0;
            m_own = nxt;
        end
    end

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic compare(input string req);
        logic [1:0]  e_stb;
        logic [7:0]  e_addr;
        logic [15:0] e_data;
        e_stb = 2'b00; e_addr = 0; e_data = 0;
        if (m_own == 0) begin
            if (!usr_req) e_stb = {loop_en, loop_we};
            e_addr = loop_addr; e_data = loop_data;
        end else if (m_own == 2) begin
            e_stb = {usr_en, usr_we}; e_addr = usr_addr; e_data = usr_data;
        end
        chk(req, "strobes", {30'd0, port_en, port_we}, {30'd0, e_stb});
        chk(req, "addr", {24'd0, port_addr}, {24'd0, e_addr});
        chk(req, "data", {16'd0, port_data}, {16'd0, e_data});
        chk(req, "busy", {31'd0, usr_busy}, {31'd0, m_own != 2});
        chk(req, "restart", {31'd0, restart}, {31'd0, m_own != 0});
        chk(req, "halt", {31'd0, loop_halt}, {31'd0, (m_own != 0) || usr_req});
        chk(req, "ready", {30'd0, loop_rdy, usr_rdy},
            {30'd0, port_rdy && (m_own <= 1), port_rdy && (m_own == 2)});
    endtask

    task automatic drive(input string req, input logic r, input logic rq,
                         input logic le, input logic lw, input logic [7:0] la, input logic [15:0] ld,
                         input logic ue, input logic uw, input logic [7:0] ua, input logic [15:0] ud,
                         input logic pr);
        @(negedge clk);
        rst = r; usr_req = rq;
        loop_en = le; loop_we = lw; loop_addr = la; loop_data = ld;
        usr_en = ue; usr_we = uw; usr_addr = ua; usr_data = ud;
        port_rdy = pr;
        #2;
        if (!r) compare(req);
    endtask

    initial begin
        #(8 * 2000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        drive("R1", 1, 0, 1, 1, 8'h11, 16'h1111, 1, 1, 8'h99, 16'h9999, 0);
        drive("R1", 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        // R1: first cycle out of reset
        drive("R1", 0, 0, 1, 1, 8'h21, 16'hA001, 0, 0, 0, 0, 0);
        chk("R1", "busy after reset", {31'd0, usr_busy}, 32'd1);
        chk("R1", "restart after reset", {31'd0, restart}, 32'd0);
        // R2: loop writes pass, user strobes ignored
        drive("R2", 0, 0, 0, 0, 8'h21, 16'hA001, 1, 1, 8'h55, 16'h5555, 0);
        drive("R2", 0, 0, 0, 0, 8'h21, 16'hA001, 1, 0, 8'h56, 16'h5556, 1);
        drive("R2", 0, 0, 1, 0, 8'h33, 16'hB002, 0, 0, 0, 0, 0);
        drive("R2", 0, 0, 0, 0, 8'h33, 16'hB002, 0, 0, 0, 0, 1);
        // R3, R5: request with nothing outstanding
        drive("R5", 0, 1, 1, 1, 8'h44, 16'hC003, 0, 0, 0, 0, 0);
        chk("R5", "loop strobe blocked", {31'd0, port_en}, 32'd0);
        drive("R3", 0, 1, 1, 1, 8'h44, 16'hC003, 0, 0, 0, 0, 0);
        chk("R3", "busy low", {31'd0, usr_busy}, 32'd0);
        // R6, R7: user write and ready
        drive("R6", 0, 1, 1, 1, 8'h45, 16'hC004, 1, 1, 8'h80, 16'hBEEF, 0);
        drive("R7", 0, 1, 0, 0, 0, 0, 0, 0, 8'h80, 16'hBEEF, 1);
        chk("R7", "user ready", {31'd0, usr_rdy}, 32'd1);
        drive("R6", 0, 1, 1, 0, 8'h46, 16'hC005, 1, 0, 8'h81, 16'h0000, 0);
        drive("R7", 0, 1, 0, 0, 0, 0, 0, 0, 8'h81, 16'h0000, 1);
        // R8, R10: drop the request, port locks
        drive("R8", 0, 0, 1, 1, 8'h47, 16'hC006, 1, 1, 8'h82, 16'h1234, 0);
        drive("R8", 0, 0, 1, 1, 8'h47, 16'hC006, 1, 1, 8'h82, 16'h1234, 0);
        chk("R8", "busy back high", {31'd0, usr_busy}, 32'd1);
        drive("R10", 0, 1, 0, 0, 0, 0, 1, 1, 8'h83, 16'h4321, 0);
        drive("R10", 0, 1, 1, 1, 8'h48, 16'hC007, 1, 1, 8'h83, 16'h4321, 1);
        chk("R10", "no strobe when locked", {31'd0, port_en}, 32'd0);
        drive("R8", 0, 0, 1, 1, 8'h48, 16'hC007, 0, 0, 0, 0, 0);
        chk("R9", "restart held", {31'd0, restart}, 32'd1);
        // R9: one-cycle reset resumes the loop
        drive("R9", 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        drive("R9", 0, 0, 1, 1, 8'h50, 16'hD000, 0, 0, 0, 0, 0);
        chk("R9", "loop resumes", {31'd0, port_en}, 32'd1);
        // R4: request while the loop write is outstanding
        drive("R4", 0, 1, 1, 1, 8'h51, 16'hD001, 1, 1, 8'h90, 16'h0F0F, 0);
        drive("R4", 0, 1, 1, 1, 8'h51, 16'hD001, 1, 1, 8'h90, 16'h0F0F, 0);
        drive("R10", 0, 1, 0, 0, 0, 0, 1, 1, 8'h90, 16'h0F0F, 0);
        chk("R4", "busy while draining", {31'd0, usr_busy}, 32'd1);
        drive("R4", 0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 1);
        chk("R7", "drain ready to loop", {31'd0, loop_rdy}, 32'd1);
        drive("R4", 0, 1, 0, 0, 0, 0, 1, 1, 8'h91, 16'h7777, 0);
        chk("R4", "granted after ready", {31'd0, usr_busy}, 32'd0);
        drive("R6", 0, 1, 0, 0, 0, 0, 0, 0, 8'h91, 16'h7777, 1);
        drive("R8", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        drive("R8", 0, 0, 1, 0, 8'h52, 16'hD002, 0, 0, 0, 0, 0);
        drive("R9", 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        drive("R1", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule